// File: doc/BRIEF.md
# Timer event flags with prescaler lock

This block is the status and control heart of a small microcontroller timer. A 16-bit counter runs freely behind a selectable prescaler. Its value is compared against five compare values, and four capture input lines are watched for a chosen edge. Each match or edge sets a bit in an 8-bit event flag register. Software clears a flag by writing a one to its position. A first mask register pairs bit for bit with the flags. A second mask register holds the counter-overflow interrupt enable, three further enables that are stored for neighbouring logic, and the 2-bit prescaler select.

One flag position is shared. A select input decides whether the fourth capture line or the fifth compare value drives it. The single interrupt output is raised by any flag whose mask bit is set, and by the overflow flag when its enable is set. In normal operation the prescaler select can be written once, and only in the first cycles after reset. With the mode pin high it can be rewritten freely.

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset every register reads 0x00, the counter output is 0 and `irq` is low.
- R2: Compare channel k (k = 1..4, value in `cmp_vals[16k-1:16k-16]`) sets flag bit 8-k (ch1 at bit 7, ch4 at bit 4). The flag becomes visible on the same clock edge at which the counter takes the compare value.
- R3: Capture line j (j = 1..3, `cap_in[j-1]`) sets flag bit 3-j (ch1 at bit 2, ch3 at bit 0) on its active edge. `cap_pol` bit 1 means rising and bit 0 means falling, and the opposite edge has no effect. The flag is visible one edge after the input changes.
- R4: Flag bit 3 is set by the capture line 4 edge (`cap_in[3]`) when `share_sel` is 1, and by a compare-5 match when `share_sel` is 0. The function not selected has no effect.
- R5: A write to the flag register (address 0) clears each bit written as one and leaves each bit written as zero unchanged.
- R6: When a hardware set and a software clear hit the same flag bit in the same cycle, the flag ends up set.
- R7: `irq` is high exactly when some flag bit and its mask-1 bit are both one, or when the overflow flag and mask-2 bit 7 are both one.
- R8: Prescaler codes 00, 01, 10 and 11 (mask-2 bits 1:0) advance the counter once every 1, 4, 8 and 16 clocks.
- R9: With `test_mode` low, the first write to mask 2 (address 2) loads the prescaler code only if it falls in the first 64 clock edges after reset. Later writes and late writes leave the code unchanged but still update bits 7:4.
- R10: With `test_mode` high, every write to mask 2 loads the prescaler code, regardless of time or count.
- R11: The overflow flag (address 3 bit 7) sets when the counter wraps from 0xFFFF to 0x0000. Writing a one to that bit clears it, and writing a zero does not.
- R12: Address map: 0 flags, 1 mask 1, 2 mask 2 (bits 3:2 read 0), 3 status (bit 7 overflow flag, bits 6:0 read 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | High lifts the prescaler write restriction |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| cmp_vals | input | 64 | Compare values of channels 1..4, channel 1 in the low 16 bits |
| cmp5_val | input | 16 | Compare value of the shared channel |
| cap_in | input | 4 | Capture lines 1..4 |
| cap_pol | input | 4 | Active edge per capture line, 1 rising |
| share_sel | input | 1 | 1 selects capture 4, 0 selects compare 5, for flag bit 3 |
| cnt_value | output | 16 | Free-running counter value |
| irq | output | 1 | Interrupt request |

## Verification
A flag register holding a wrong bit shows up on the next read of address 0 and, if the bit is masked in, on `irq` in the same cycle. A wrong prescaler code or a lock that opens again shows up within at most 16 clocks as a wrong step period on `cnt_value`. The bench times the gaps between counter steps exactly, so one stray write that got through is enough to detect it. Compare and capture timing is checked on the exact edge, so a flag that arrives one cycle early or late is reported right away.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_FLAGS = 2'd0,
    REG_MASK1 = 2'd1,
    REG_MASK2 = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  localparam int NUM_CMP = 4;
  localparam int NUM_CAP = 4;
  localparam int PS_W    = 4;

  // Low prescaler-count bits that must all be one for a counter step.
  function automatic logic [PS_W-1:0] presc_mask(input logic [1:0] code);
    case (code)
      2'd0:    presc_mask = 4'h0;
      2'd1:    presc_mask = 4'h3;
      2'd2:    presc_mask = 4'h7;
      default: presc_mask = 4'hF;
    endcase
  endfunction
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core import tmr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       presc,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             tick,
  output logic             wrap
);
  logic [PS_W-1:0]  pcnt_q, pcnt_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [PS_W-1:0]  pmask;

  always_comb begin
    pmask     = presc_mask(presc);
    tick      = ((pcnt_q & pmask) == pmask);
    count_nxt = count_q + 1'b1;
    wrap      = tick && (&count_q);
    pcnt_d    = pcnt_q + 1'b1;
    count_d   = tick ? count_nxt : count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      count_q <= '0;
    end else begin
      pcnt_q  <= pcnt_d;
      count_q <= count_d;
    end
  end

  assign count = count_q;

  // R8: between prescaler steps the counter holds its value
  a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_q));
endmodule

// File: rtl/tmr_event_sense.sv
module tmr_event_sense import tmr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [CNT_W-1:0]         count_nxt,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_vals,
  input  logic [CNT_W-1:0]         cmp5_val,
  input  logic [NUM_CAP-1:0]       cap_in,
  input  logic [NUM_CAP-1:0]       cap_pol,
  input  logic                     share_sel,
  output logic [7:0]               set_vec
);
  logic [NUM_CAP-1:0] prev_q;
  logic [NUM_CMP-1:0] cmp_hit;
  logic [NUM_CAP-1:0] cap_hit;
  logic               cmp5_hit;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign cmp_hit[k] = tick && (count_nxt == cmp_vals[k*CNT_W +: CNT_W]);
  end

  for (genvar j = 0; j < NUM_CAP; j++) begin : g_cap
    assign cap_hit[j] = cap_pol[j] ? (cap_in[j] & ~prev_q[j])
                                   : (~cap_in[j] & prev_q[j]);
  end

  assign cmp5_hit = tick && (count_nxt == cmp5_val);

  always_comb begin
    set_vec    = '0;
    set_vec[7] = cmp_hit[0];
    set_vec[6] = cmp_hit[1];
    set_vec[5] = cmp_hit[2];
    set_vec[4] = cmp_hit[3];
    set_vec[3] = share_sel ? cap_hit[3] : cmp5_hit;
    set_vec[2] = cap_hit[0];
    set_vec[1] = cap_hit[1];
    set_vec[0] = cap_hit[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cap_in;
  end
endmodule

// File: rtl/tmr_presc_lock.sv
module tmr_presc_lock #(
  parameter int WINDOW = 64,
  localparam int WIN_W = $clog2(WINDOW + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_mode,
  input  logic       wr_en,
  input  logic [1:0] wr_code,
  output logic [1:0] presc
);
  logic [WIN_W-1:0] win_q, win_d;
  logic             used_q, used_d;
  logic [1:0]       code_q, code_d;
  logic             win_open, accept;

  always_comb begin
    win_open = (win_q < WIN_W'(WINDOW));
    win_d    = win_open ? win_q + 1'b1 : win_q;
    accept   = wr_en && (test_mode || (win_open && !used_q));
    used_d   = used_q | accept;
    code_d   = accept ? wr_code : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      used_q <= 1'b0;
      code_q <= 2'b00;
    end else begin
      win_q  <= win_d;
      used_q <= used_d;
      code_q <= code_d;
    end
  end

  assign presc = code_q;

  // R9: once the single write is spent, normal mode freezes the code
  a_r9_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q && !test_mode) |=> $stable(code_q));
  // R9: the window counter saturates at the window length
  a_r9_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= WIN_W'(WINDOW));
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit import tmr_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int WINDOW = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     test_mode,
  input  logic                     bus_wr,
  input  logic [1:0]               bus_addr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_vals,
  input  logic [CNT_W-1:0]         cmp5_val,
  input  logic [NUM_CAP-1:0]       cap_in,
  input  logic [NUM_CAP-1:0]       cap_pol,
  input  logic                     share_sel,
  output logic [CNT_W-1:0]         cnt_value,
  output logic                     irq
);
  logic [CNT_W-1:0] count, count_nxt;
  logic             tick, wrap;
  logic [1:0]       presc;
  logic [7:0]       set_vec;
  logic [7:0]       flags_q, flags_d;
  logic [7:0]       mask1_q, mask1_d;
  logic [3:0]       mhi_q, mhi_d;
  logic             tof_q, tof_d;
  logic             wr_flags, wr_mask1, wr_mask2, wr_stat;

  tmr_count_core #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .presc(presc),
    .count(count), .count_nxt(count_nxt), .tick(tick), .wrap(wrap)
  );

  tmr_event_sense #(.CNT_W(CNT_W)) u_sense (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count_nxt(count_nxt),
    .cmp_vals(cmp_vals), .cmp5_val(cmp5_val), .cap_in(cap_in),
    .cap_pol(cap_pol), .share_sel(share_sel), .set_vec(set_vec)
  );

  tmr_presc_lock #(.WINDOW(WINDOW)) u_lock (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .wr_en(wr_mask2), .wr_code(bus_wdata[1:0]), .presc(presc)
  );

  always_comb begin
    wr_flags = bus_wr && (bus_addr == REG_FLAGS);
    wr_mask1 = bus_wr && (bus_addr == REG_MASK1);
    wr_mask2 = bus_wr && (bus_addr == REG_MASK2);
    wr_stat  = bus_wr && (bus_addr == REG_STAT);

    flags_d = flags_q;
    if (wr_flags) flags_d = flags_d & ~bus_wdata;
    flags_d = flags_d | set_vec;

    tof_d = tof_q;
    if (wr_stat && bus_wdata[7]) tof_d = 1'b0;
    tof_d = tof_d | wrap;

    mask1_d = wr_mask1 ? bus_wdata : mask1_q;
    mhi_d   = wr_mask2 ? bus_wdata[7:4] : mhi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask1_q <= '0;
      mhi_q   <= '0;
      tof_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      mask1_q <= mask1_d;
      mhi_q   <= mhi_d;
      tof_q   <= tof_d;
    end
  end

  always_comb begin
    case (bus_addr)
      REG_FLAGS: bus_rdata = flags_q;
      REG_MASK1: bus_rdata = mask1_q;
      REG_MASK2: bus_rdata = {mhi_q, 2'b00, presc};
      default:   bus_rdata = {tof_q, 7'b0};
    endcase
  end

  assign irq       = (|(flags_q & mask1_q)) | (tof_q & mhi_q[3]);
  assign cnt_value = count;

  // R6: any hardware set lands in the flag register on the next edge
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
  // R5: bits written as one without a concurrent set end up cleared
  a_r5_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flags |=> ((flags_q & $past(bus_wdata & ~set_vec)) == 8'h00));
  // R11: a counter wrap raises the overflow flag
  a_r11_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> tof_q);
  // R7: no pending source means no request
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == 8'h00 && !tof_q) |-> !irq);
endmodule

// File: tb/tmr_flag_unit_test.sv
`timescale 1ns/100ps
module tmr_flag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        test_mode;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [63:0] cmp_vals;
  logic [15:0] cmp5_val;
  logic [3:0]  cap_in;
  logic [3:0]  cap_pol;
  logic        share_sel;
  logic [15:0] cnt_value;
  logic        irq;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 0;

  typedef struct {
    string       req;
    int          kind;   // 0 rdata, 1 irq, 2 counter
    logic [15:0] exp;
  } item_t;
  item_t q[$];

  tmr_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_vals(cmp_vals), .cmp5_val(cmp5_val), .cap_in(cap_in),
    .cap_pol(cap_pol), .share_sel(share_sel), .cnt_value(cnt_value), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // Monitor: compare pending expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = {8'h00, bus_rdata};
        1:       act = {15'h0, irq};
        default: act = cnt_value;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] e);
    bus_addr = a;
    q.push_back('{req, 0, {8'h00, e}});
    tick(1);
  endtask

  task automatic chk_irq(input string req, input logic e);
    q.push_back('{req, 1, {15'h0, e}});
    tick(1);
  endtask

  task automatic chk_cnt(input string req, input logic [15:0] e);
    q.push_back('{req, 2, e});
  endtask

  task automatic do_reset(input logic tm);
    rst_n = 1'b0; test_mode = tm; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    cmp_vals = {16'hC000, 16'hB000, 16'hA000, 16'h9000};
    cmp5_val = 16'hD000; cap_in = 4'h0; cap_pol = 4'hF; share_sel = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  // Measure one full step period of the counter
  task automatic chk_div(input string req, input int n);
    logic [15:0] c;
    c = cnt_value;
    for (int i = 0; i < 40 && cnt_value == c; i++) tick(1);
    c = cnt_value;
    chk_cnt(req, c);
    if (n > 1) begin
      tick(n - 1);
      chk_cnt(req, c);
    end
    tick(1);
    chk_cnt(req, c + 16'd1);
    tick(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    // ---- Phase A: normal mode, early prescaler write
    do_reset(1'b0);
    chk_cnt("R1", 16'h0000);
    chk_reg("R1", 2'd0, 8'h00);
    chk_reg("R1", 2'd1, 8'h00);
    chk_reg("R1", 2'd2, 8'h00);
    chk_reg("R1", 2'd3, 8'h00);
    chk_irq("R1", 1'b0);
    wr(2'd2, 8'h8D);
    chk_reg("R9 R12 first write", 2'd2, 8'h81);
    wr(2'd2, 8'h03);
    chk_reg("R9 second write ignored", 2'd2, 8'h01);
    chk_div("R8 div4", 4);

    // ---- Phase B: normal mode, write after the window
    do_reset(1'b0);
    tick(70);
    wr(2'd2, 8'h83);
    chk_reg("R9 late write", 2'd2, 8'h80);
    chk_div("R9 div1 kept", 1);

    // ---- Phase C: test mode
    do_reset(1'b1);
    tick(80);
    wr(2'd2, 8'h03);
    chk_reg("R10", 2'd2, 8'h03);
    chk_div("R8 R10 div16", 16);
    wr(2'd2, 8'h02);
    chk_reg("R10", 2'd2, 8'h02);
    chk_div("R8 R10 div8", 8);
    wr(2'd2, 8'h00);
    chk_div("R8 R10 div1", 1);

    // R2: compare channel 2 on the exact edge
    c = cnt_value;
    cmp_vals[31:16] = c + 16'd3;
    chk_reg("R2", 2'd0, 8'h00);
    chk_reg("R2", 2'd0, 8'h00);
    chk_reg("R2", 2'd0, 8'h00);
    chk_reg("R2 ch2", 2'd0, 8'h40);
    // R2/R5: channels 1 and 3 together
    c = cnt_value;
    cmp_vals[15:0]  = c + 16'd2;
    cmp_vals[47:32] = c + 16'd2;
    chk_reg("R2", 2'd0, 8'h40);
    chk_reg("R2", 2'd0, 8'h40);
    chk_reg("R2 ch1 ch3", 2'd0, 8'hE0);
    // R7: masking
    wr(2'd1, 8'h10);
    chk_irq("R7 unmatched mask", 1'b0);
    wr(2'd1, 8'h40);
    chk_reg("R12 mask1", 2'd1, 8'h40);
    chk_irq("R7 matched", 1'b1);
    wr(2'd0, 8'h20);
    chk_reg("R5 partial clear", 2'd0, 8'hC0);
    chk_irq("R7", 1'b1);
    wr(2'd0, 8'hC0);
    chk_reg("R5 multi clear", 2'd0, 8'h00);
    chk_irq("R7", 1'b0);
    wr(2'd1, 8'h00);

    // R3: captures
    cap_pol = 4'b1101;
    cap_in[0] = 1'b1;
    chk_reg("R3", 2'd0, 8'h00);
    chk_reg("R3 ch1 rise", 2'd0, 8'h04);
    cap_in[0] = 1'b0;
    chk_reg("R3", 2'd0, 8'h04);
    chk_reg("R3 fall ignored", 2'd0, 8'h04);
    wr(2'd0, 8'h04);
    cap_in[1] = 1'b1;
    chk_reg("R3", 2'd0, 8'h00);
    chk_reg("R3 ch2 rise ignored", 2'd0, 8'h00);
    cap_in[1] = 1'b0;
    chk_reg("R3", 2'd0, 8'h00);
    chk_reg("R3 ch2 fall", 2'd0, 8'h02);
    wr(2'd0, 8'h02);
    cap_in[2] = 1'b1;
    chk_reg("R3", 2'd0, 8'h00);
    chk_reg("R3 ch3 rise", 2'd0, 8'h01);
    wr(2'd0, 8'h01);

    // R6: set and clear in the same cycle
    cap_in[0] = 1'b1;
    tick(1);
    chk_reg("R6 prep", 2'd0, 8'h04);
    cap_in[0] = 1'b0;
    tick(1);
    cap_in[0] = 1'b1;
    wr(2'd0, 8'h04);
    chk_reg("R6 set wins", 2'd0, 8'h04);
    wr(2'd0, 8'h04);
    chk_reg("R5 clear", 2'd0, 8'h00);

    // R4: shared flag
    share_sel = 1'b1;
    c = cnt_value;
    cmp5_val = c + 16'd2;
    chk_reg("R4", 2'd0, 8'h00);
    chk_reg("R4", 2'd0, 8'h00);
    chk_reg("R4 cmp5 ignored", 2'd0, 8'h00);
    cap_in[3] = 1'b1;
    chk_reg("R4", 2'd0, 8'h00);
    chk_reg("R4 cap4", 2'd0, 8'h08);
    wr(2'd0, 8'h08);
    share_sel = 1'b0;
    cap_in[3] = 1'b0;
    tick(1);
    cap_in[3] = 1'b1;
    chk_reg("R4", 2'd0, 8'h00);
    chk_reg("R4 cap4 ignored", 2'd0, 8'h00);
    c = cnt_value;
    cmp5_val = c + 16'd2;
    chk_reg("R4", 2'd0, 8'h00);
    chk_reg("R4", 2'd0, 8'h00);
    chk_reg("R4 cmp5", 2'd0, 8'h08);
    wr(2'd0, 8'h08);

    // R11: overflow
    wr(2'd2, 8'h80);
    for (int i = 0; i < 70000 && cnt_value != 16'hFFFF; i++) tick(1);
    chk_reg("R11", 2'd3, 8'h00);
    chk_reg("R11 wrap", 2'd3, 8'h80);
    chk_irq("R7 R11 overflow irq", 1'b1);
    wr(2'd3, 8'h00);
    chk_reg("R11 zero write", 2'd3, 8'h80);
    wr(2'd3, 8'h80);
    chk_reg("R11 cleared", 2'd3, 8'h00);
    chk_irq("R7 R11", 1'b0);

    tick(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule